// File: doc/BRIEF.md
# UART Interrupt Status and Mask Controller

This block keeps the interrupt state of a serial port. Five live status levels arrive from the receive and transmit FIFOs. Five single-cycle event pulses arrive from the receiver and the modem logic. Whenever one of these inputs is high, the matching bit of a sticky status register is set. The bit then stays set until software clears it by writing a one to that bit position.

Software changes the interrupt mask only through two write strobes. One strobe sets mask bits and the other clears them. A write to the mask's own address changes nothing. The block drives one level interrupt line, which is high while any masked-in sticky bit is set. The output is registered.

The block connects to a simple register write port (address, data, strobe). Read multiplexing, the FIFOs and the serial shifters sit outside it. The current mask and sticky status are brought out as plain outputs for the read path.

Top module: `uart_irq_ctl`

## Requirements
- R1: The live status input has five bits, with these positions: bit 0 receive trigger level reached, bit 1 receive empty, bit 2 receive full, bit 3 transmit empty, bit 4 transmit full. Any live bit that is high at a clock edge sets the same bit of `status_o` from that edge on.
- R2: A sticky status bit stays set after its live or event source drops, until it is cleared by a write.
- R3: The event pulse input bits 0..4 set sticky status bits 5..9: bit 5 receive overrun, bit 6 framing error, bit 7 parity error, bit 8 receive timeout, bit 9 modem status change.
- R4: A write to word address 0x2 ORs `wr_data` into the mask.
- R5: A write to word address 0x3 clears every mask bit where `wr_data` holds a one, and leaves the other mask bits as they were.
- R6: A write to word address 0x4, which is the mask's own address, leaves the mask unchanged.
- R7: A write to word address 0x5 clears every sticky status bit where `wr_data` holds a one. Bits where `wr_data` holds a zero are unchanged.
- R8: When a live bit or an event pulse sets a status bit in the same cycle that a write to address 0x5 clears it, the bit ends up set.
- R9: `irq_o` is high exactly when the bitwise AND of the mask and the sticky status was nonzero one clock earlier, so it follows a register change by one clock.
- R10: While reset is asserted, the mask, the sticky status and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 10 | Write data |
| live_stat | input | 5 | Live FIFO status levels |
| evt_pulse | input | 5 | Event pulses |
| mask_o | output | 10 | Current interrupt mask |
| status_o | output | 10 | Current sticky status |
| irq_o | output | 1 | Level interrupt request |

## Verification
Single live bits and single event bits are applied and then removed, so that a bit which latches can be told apart from one that only follows its source.

Mask set and clear writes are made with multi-bit data. These show whether an untouched bit is preserved or lost. A write to the mask's own address uses all-ones data, so any leak into the mask is visible.

A status clear with all-ones data is made in the same cycle as new set sources. This separates set-wins behaviour from clear-wins behaviour.

Each row also checks the interrupt line against the state of the row before it. That catches an unmasked, a combinational or a late interrupt.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_STAT = 3'd1,
      SEL_MSET = 3'd2,
      SEL_MCLR = 3'd3,
      SEL_MRO  = 3'd4
   } wsel_e;

   localparam int unsigned DEF_ADDR_W = 4;
   localparam int unsigned DEF_N_LIVE = 5;
   localparam int unsigned DEF_N_EVT  = 5;

   localparam logic [DEF_ADDR_W-1:0] DEF_A_MSET = 4'h2;
   localparam logic [DEF_ADDR_W-1:0] DEF_A_MCLR = 4'h3;
   localparam logic [DEF_ADDR_W-1:0] DEF_A_MASK = 4'h4;
   localparam logic [DEF_ADDR_W-1:0] DEF_A_STAT = 4'h5;

endpackage

// File: rtl/uirq_wr_decode.sv
module uirq_wr_decode
   import uirq_pkg::*;
#(
   parameter int unsigned ADDR_W = DEF_ADDR_W,
   parameter logic [ADDR_W-1:0] A_MSET = DEF_A_MSET,
   parameter logic [ADDR_W-1:0] A_MCLR = DEF_A_MCLR,
   parameter logic [ADDR_W-1:0] A_MASK = DEF_A_MASK,
   parameter logic [ADDR_W-1:0] A_STAT = DEF_A_STAT
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output wsel_e             sel
);

   if (A_MSET == A_MCLR || A_MSET == A_MASK || A_MSET == A_STAT ||
       A_MCLR == A_MASK || A_MCLR == A_STAT || A_MASK == A_STAT) begin : g_bad_map
      $error("uirq_wr_decode: register addresses must be distinct");
   end

   always_comb begin
      sel = SEL_NONE;
      if (wr_en) begin
         if (wr_addr == A_STAT)      sel = SEL_STAT;
         else if (wr_addr == A_MSET) sel = SEL_MSET;
         else if (wr_addr == A_MCLR) sel = SEL_MCLR;
         else if (wr_addr == A_MASK) sel = SEL_MRO;
      end
   end

endmodule

// File: rtl/uirq_mask_reg.sv
module uirq_mask_reg #(
   parameter int unsigned NB = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_stb,
   input  logic          clr_stb,
   input  logic [NB-1:0] wdata,
   output logic [NB-1:0] mask_q
);

   if (NB < 1) begin : g_bad_nb
      $error("uirq_mask_reg: NB must be at least 1");
   end

   logic [NB-1:0] mask_d;

   always_comb begin
      mask_d = mask_q;
      if (set_stb)      mask_d = mask_q | wdata;
      else if (clr_stb) mask_d = mask_q & ~wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end

   // R4: written ones appear in the mask after a set strobe
   p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> ((mask_q & $past(wdata)) == $past(wdata)));

   // R5: written ones vanish and other bits survive after a clear strobe
   p_mask_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && !set_stb) |=> (mask_q == ($past(mask_q) & ~$past(wdata))));

endmodule

// File: rtl/uirq_sticky_stat.sv
module uirq_sticky_stat #(
   parameter int unsigned NB = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] set_i,
   input  logic [NB-1:0] clr_i,
   output logic [NB-1:0] stat_o
);

   if (NB < 1) begin : g_bad_nb
      $error("uirq_sticky_stat: NB must be at least 1");
   end

   for (genvar b = 0; b < NB; b++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= set_i[b] | (q & ~clr_i[b]);
      end
      assign stat_o[b] = q;
   end

   // R1, R3, R8: any set source leaves its bit high on the next cycle
   p_set_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((stat_o & $past(set_i)) == $past(set_i)));

   // R2: an uncleared bit never drops
   p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat_o) != '0) |=> ((stat_o & $past(stat_o) & ~$past(clr_i)) ==
                                 ($past(stat_o) & ~$past(clr_i))));

   // R7: cleared bits without a set source are low afterwards
   p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i != '0) |=> ((stat_o & $past(clr_i) & ~$past(set_i)) == '0));

endmodule

// File: rtl/uirq_out.sv
module uirq_out #(
   parameter int unsigned NB      = 10,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] mask_i,
   input  logic [NB-1:0] stat_i,
   output logic          irq_o
);

   logic hit;
   assign hit = |(mask_i & stat_i);

   if (REG_OUT) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= hit;
      end
      assign irq_o = irq_q;
   end else begin : g_comb
      assign irq_o = hit;
   end

endmodule

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
   import uirq_pkg::*;
#(
   parameter int unsigned ADDR_W = DEF_ADDR_W,
   parameter int unsigned N_LIVE = DEF_N_LIVE,
   parameter int unsigned N_EVT  = DEF_N_EVT,
   parameter logic [ADDR_W-1:0] A_MSET = DEF_A_MSET,
   parameter logic [ADDR_W-1:0] A_MCLR = DEF_A_MCLR,
   parameter logic [ADDR_W-1:0] A_MASK = DEF_A_MASK,
   parameter logic [ADDR_W-1:0] A_STAT = DEF_A_STAT,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [N_LIVE+N_EVT-1:0] wr_data,
   input  logic [N_LIVE-1:0]       live_stat,
   input  logic [N_EVT-1:0]        evt_pulse,
   output logic [N_LIVE+N_EVT-1:0] mask_o,
   output logic [N_LIVE+N_EVT-1:0] status_o,
   output logic                    irq_o
);

   localparam int unsigned NB = N_LIVE + N_EVT;

   if (N_LIVE < 1 || N_EVT < 1) begin : g_bad_src
      $error("uart_irq_ctl: need at least one live and one event source");
   end

   wsel_e         sel;
   logic [NB-1:0] set_vec;
   logic [NB-1:0] clr_vec;

   uirq_wr_decode #(
      .ADDR_W (ADDR_W),
      .A_MSET (A_MSET),
      .A_MCLR (A_MCLR),
      .A_MASK (A_MASK),
      .A_STAT (A_STAT)
   ) u_dec (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .sel     (sel)
   );

   assign set_vec = {evt_pulse, live_stat};
   assign clr_vec = (sel == SEL_STAT) ? wr_data : '0;

   uirq_mask_reg #(.NB(NB)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (sel == SEL_MSET),
      .clr_stb (sel == SEL_MCLR),
      .wdata   (wr_data),
      .mask_q  (mask_o)
   );

   uirq_sticky_stat #(.NB(NB)) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .clr_i  (clr_vec),
      .stat_o (status_o)
   );

   uirq_out #(.NB(NB), .REG_OUT(REG_OUT)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .mask_i (mask_o),
      .stat_i (status_o),
      .irq_o  (irq_o)
   );

   // R6: a write to the mask's own address leaves it unchanged
   p_mask_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_MASK) |=> $stable(mask_o));

   if (REG_OUT) begin : g_irq_chk
      // R9: line low one clock after no masked bit is pending
      p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
         ((mask_o & status_o) == '0) |=> !irq_o);
      // R9: line high one clock after a masked bit is pending
      p_irq_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
         ((mask_o & status_o) != '0) |=> irq_o);
   end

   // R10: everything idle while in reset
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_zero_r10: assert (mask_o == '0 && status_o == '0 && !irq_o);
      end
   end

endmodule

// File: tb/sim_uart_irq_ctl.sv
module sim_uart_irq_ctl;

   localparam int NV = 19;
   localparam int VW = 45;

   // {wen, addr[3:0], data[9:0], live[4:0], evt[4:0], exp_mask[9:0], exp_stat[9:0]}
   localparam logic [VW-1:0] VEC [NV] = '{
      {1'b0, 4'h0, 10'h000, 5'h01, 5'h00, 10'h000, 10'h001},
      {1'b0, 4'h0, 10'h000, 5'h00, 5'h00, 10'h000, 10'h001},
      {1'b1, 4'h2, 10'h001, 5'h00, 5'h00, 10'h001, 10'h001},
      {1'b0, 4'h0, 10'h000, 5'h00, 5'h00, 10'h001, 10'h001},
      {1'b0, 4'h0, 10'h000, 5'h00, 5'h01, 10'h001, 10'h021},
      {1'b1, 4'h5, 10'h001, 5'h00, 5'h00, 10'h001, 10'h020},
      {1'b0, 4'h0, 10'h000, 5'h00, 5'h00, 10'h001, 10'h020},
      {1'b1, 4'h2, 10'h3E0, 5'h00, 5'h00, 10'h3E1, 10'h020},
      {1'b0, 4'h0, 10'h000, 5'h00, 5'h00, 10'h3E1, 10'h020},
      {1'b1, 4'h3, 10'h020, 5'h00, 5'h00, 10'h3C1, 10'h020},
      {1'b1, 4'h4, 10'h3FF, 5'h00, 5'h00, 10'h3C1, 10'h020},
      {1'b1, 4'h5, 10'h3FF, 5'h04, 5'h10, 10'h3C1, 10'h204},
      {1'b0, 4'h0, 10'h000, 5'h0A, 5'h06, 10'h3C1, 10'h2CE},
      {1'b1, 4'h3, 10'h3FF, 5'h00, 5'h00, 10'h000, 10'h2CE},
      {1'b0, 4'h0, 10'h000, 5'h00, 5'h00, 10'h000, 10'h2CE},
      {1'b1, 4'h5, 10'h0C0, 5'h00, 5'h00, 10'h000, 10'h20E},
      {1'b1, 4'h2, 10'h010, 5'h10, 5'h00, 10'h010, 10'h21E},
      {1'b0, 4'h0, 10'h000, 5'h00, 5'h00, 10'h010, 10'h21E},
      {1'b0, 4'h0, 10'h000, 5'h00, 5'h08, 10'h010, 10'h31E}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [9:0] wr_data = '0;
   logic [4:0] live_stat = '0;
   logic [4:0] evt_pulse = '0;
   logic [9:0] mask_o;
   logic [9:0] status_o;
   logic       irq_o;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   uart_irq_ctl u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .live_stat (live_stat),
      .evt_pulse (evt_pulse),
      .mask_o    (mask_o),
      .status_o  (status_o),
      .irq_o     (irq_o)
   );

   function automatic string row_tag(int i);
      case (i)
         0, 16:          return "R1";
         1:              return "R2";
         2, 7:           return "R4";
         4, 12, 18:      return "R3";
         5, 15:          return "R7";
         9, 13:          return "R5";
         10:             return "R6";
         11:             return "R8";
         default:        return "R9";
      endcase
   endfunction

   task automatic check(string req, string what, logic [9:0] act, logic [9:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   initial begin
      #(200000 * 8);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [9:0] prev_m;
      logic [9:0] prev_s;
      prev_m = '0;
      prev_s = '0;

      repeat (3) @(negedge clk);
      check("R10", "mask in reset",   mask_o,   10'h000);
      check("R10", "status in reset", status_o, 10'h000);
      check("R10", "irq in reset",    {9'd0, irq_o}, 10'h000);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         v = VEC[i];
         wr_en     = v[44];
         wr_addr   = v[43:40];
         wr_data   = v[39:30];
         live_stat = v[29:25];
         evt_pulse = v[24:20];
         @(negedge clk);
         check(row_tag(i), "mask",   mask_o,   v[19:10]);
         check(row_tag(i), "status", status_o, v[9:0]);
         // R9: line reflects the previous row's masked status
         check("R9", "irq", {9'd0, irq_o}, {9'd0, |(prev_m & prev_s)});
         prev_m = v[19:10];
         prev_s = v[9:0];
      end

      wr_en = 1'b0;
      live_stat = '0;
      evt_pulse = '0;
      // R10: reset from a busy state clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R10", "mask after reset",   mask_o,   10'h000);
      check("R10", "status after reset", status_o, 10'h000);
      check("R10", "irq after reset",    {9'd0, irq_o}, 10'h000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", "status after release", status_o, 10'h000);

      // R7: clear of an already-clear bit is harmless; R1 single bit latches
      live_stat = 5'h08;
      @(negedge clk);
      live_stat = 5'h00;
      wr_en = 1'b1; wr_addr = 4'h5; wr_data = 10'h001;
      @(negedge clk);
      wr_en = 1'b0;
      check("R7", "clear of other bit keeps bit 3", status_o, 10'h008);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule